// File: doc/BRIEF.md
# Quinary dual-pair symbol encoder

This block turns one 4-bit nibble per symbol period into two five-level line symbols, one for line A and one for line B. Each level is -2, -1, 0, +1 or +2 and leaves the block as 3-bit two's complement. A 33-stage maximal-length scrambler advances once per symbol. Its feedback polynomial is picked by a strap: x^33+x^13+1 for the clock master, x^33+x^20+1 for the slave. Tapped history bits of the scrambler drive three things: a per-line 2-bit scramble word that depends on symbol parity, a swap of those words between the two lines, and a per-line sign flip applied after a four-level mapper. The sign flip is what raises the four-level alphabet to five levels.

A transmit-enable input frames the stream. While it is low the block sends idle symbols, which are the all-zero nibble passed through the full scrambling path. When it rises the block inserts a two-symbol start delimiter before data. When it falls it inserts a two-symbol end delimiter before returning to idle. A receiver-ready input controls whether the line-A/B "X" scramble word follows symbol parity or is held at its even-symbol value.

The surrounding transmitter pulses `sym_en` once per symbol period. The encoder registers both levels and raises `sym_v_o` for one cycle in the following clock.

Top module: `qpair_sym_enc`

## Requirements
- R1: While `rst_n` is low at a clock edge, `a_o` and `b_o` become 0, `sym_v_o` becomes 0, the framer returns to idle, the symbol index becomes even (0), and the scrambler history takes the value of parameter `SEED`: bit k of `SEED` holds s[n-1-k] for the first symbol.
- R2: Each symbol uses scrambler bit s[n] = s[n-13] XOR s[n-33] when `slave_sel`=0, and s[n] = s[n-20] XOR s[n-33] when `slave_sel`=1. The history shifts in s[n] only on a cycle with `sym_en`=1. Cycles without `sym_en` leave it untouched.
- R3: The data pair for line A is {NOT nibble[2], nibble[3]} and for line B is {NOT nibble[0], nibble[1]}, with the first-named bit as the MSB. Each pair is XORed with a 2-bit word Sa (line A) or Sb (line B). Sa=X and Sb=Y when s[n]=1. Sa=Y and Sb=X when s[n]=0.
- R4: With x[n] = s[n-3] XOR s[n-8], X on even symbols is 2'b10 for x=0 and 2'b01 for x=1, and on odd symbols it is the bitwise inverse. When `rx_ready`=0, the even value is used on every symbol. With y[n] = s[n-4] XOR s[n-6], Y on even symbols is 2'b00 for y=0 and 2'b11 for y=1, and on odd symbols it is the inverse, whatever `rx_ready` is. The symbol index alternates even/odd on every `sym_en`.
- R5: The mapper turns the scrambled pair 2'b01 into +1, 2'b00 into 0, 2'b10 into -1 and 2'b11 into -2.
- R6: The mapped level on line A is negated when a[n] = s[n-1] XOR s[n-5] is 1. Line B is negated when b[n] = s[n-2] XOR s[n-12] is 1.
- R7: In idle, a symbol with `tx_en`=1 starts the first start-delimiter symbol, and the next symbol is the second delimiter symbol whatever `tx_en` is. Data symbols follow while `tx_en`=1. A data-state symbol with `tx_en`=0 is the first end-delimiter symbol, the next is the second whatever `tx_en` is, then idle resumes. The nibble is ignored on every delimiter and idle symbol.
- R8: On the first delimiter symbol both lines carry -2 sign-flipped by a[n] and b[n], giving ±2. On the second, line A carries ±2 the same way and line B carries 0.
- R9: `sym_v_o` is 1 in exactly the cycle after each `sym_en` cycle. `a_o` and `b_o` change only in that cycle.
- R10: `a_o` and `b_o` never hold the codes 3'b011 or 3'b100.
- R11: An idle symbol equals the encoding of the nibble 4'b0000 through R3 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_sel | input | 1 | Strap: 0 selects master polynomial, 1 selects slave polynomial |
| rx_ready | input | 1 | Local receiver ready; enables parity on the X word |
| tx_en | input | 1 | Frame request; high for data |
| sym_en | input | 1 | One-cycle pulse per symbol period |
| nib_i | input | 4 | Data nibble for the current symbol |
| a_o | output | 3 | Line A level, two's complement |
| b_o | output | 3 | Line B level, two's complement |
| sym_v_o | output | 1 | Pulse marking fresh levels |

## Verification
The assertions assume that `slave_sel` is a static strap that changes only while reset is held. They also assume `sym_en` is a single-cycle pulse that may recur back to back or after gaps of any length. The stimulus changes the strap only inside a reset. It drives `sym_en` either on consecutive cycles or with random idle cycles between pulses, and it draws nibbles, `tx_en` and `rx_ready` from a fixed-seed random source. Directed runs add the delimiter edge cases: a one-symbol transmit request, `tx_en` toggling during second delimiter symbols, and the all-zero and all-one nibbles.

// File: rtl/qpair_pkg.sv
// Package: shared types and tap positions for the quinary dual-pair encoder.
// Assumes: history index k of the scrambler holds s[n-1-k].
package qpair_pkg;

    localparam int PRBS_LEN   = 33;
    localparam int FB_MASTER  = 12;   // s[n-13]
    localparam int FB_SLAVE   = 19;   // s[n-20]
    localparam int TAP_A0     = 0;    // s[n-1]
    localparam int TAP_A1     = 4;    // s[n-5]
    localparam int TAP_B0     = 1;    // s[n-2]
    localparam int TAP_B1     = 11;   // s[n-12]
    localparam int TAP_X0     = 2;    // s[n-3]
    localparam int TAP_X1     = 7;    // s[n-8]
    localparam int TAP_Y0     = 3;    // s[n-4]
    localparam int TAP_Y1     = 5;    // s[n-6]
    localparam int LVL_W      = 3;
    localparam int NLANE      = 2;

    typedef logic signed [LVL_W-1:0] lvl_t;

    // Framer state between symbols
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_SSD2 = 2'd1,
        FS_DATA = 2'd2,
        FS_ESD2 = 2'd3
    } frame_st_e;

    // What the current symbol carries
    typedef enum logic [1:0] {
        SK_IDLE = 2'd0,
        SK_DATA = 2'd1,
        SK_DEL1 = 2'd2,
        SK_DEL2 = 2'd3
    } sym_kind_e;

    // How a lane forms its base level before the sign flip
    typedef enum logic [1:0] {
        LK_BITS = 2'd0,
        LK_FULL = 2'd1,
        LK_ZERO = 2'd2
    } lane_kind_e;

endpackage

// File: rtl/qpair_prbs33.sv
// Module: 33-stage maximal-length scrambler with strap-selected feedback.
// Presents s[n] and the four derived tap bits for the current symbol and
// shifts once per symbol. Assumes SEED is nonzero and slave_sel is static.
module qpair_prbs33
    import qpair_pkg::*;
#(
    parameter logic [PRBS_LEN-1:0] SEED = 33'h1_5A5A_C3C3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic slave_sel,
    output logic s_now,
    output logic a_bit,
    output logic b_bit,
    output logic x_bit,
    output logic y_bit
);

    logic [PRBS_LEN-1:0] hist;

    // Current scrambler output from the selected feedback pair
    always_comb begin
        s_now = hist[PRBS_LEN-1] ^ (slave_sel ? hist[FB_SLAVE] : hist[FB_MASTER]);
        a_bit = hist[TAP_A0] ^ hist[TAP_A1];
        b_bit = hist[TAP_B0] ^ hist[TAP_B1];
        x_bit = hist[TAP_X0] ^ hist[TAP_X1];
        y_bit = hist[TAP_Y0] ^ hist[TAP_Y1];
    end

    // History register: load seed on reset, shift on each symbol
    always_ff @(posedge clk) begin
        if (!rst_n)   hist <= SEED;
        else if (adv) hist <= {hist[PRBS_LEN-2:0], s_now};
    end

    a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        hist != '0);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(hist));

    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> hist[PRBS_LEN-1:1] == $past(hist[PRBS_LEN-2:0]));

endmodule

// File: rtl/qpair_scr_word.sv
// Module: forms the X and Y scramble words from tap bits and symbol parity,
// then steers them to lines A and B under control of s[n].
// Assumes: odd=1 marks an odd symbol index. Purely combinational.
module qpair_scr_word (
    input  logic       s_now,
    input  logic       x_bit,
    input  logic       y_bit,
    input  logic       odd,
    input  logic       rx_ready,
    output logic [1:0] sa,
    output logic [1:0] sb
);

    logic [1:0] x_even, x_word, y_even, y_word;

    // Parity-dependent words and line swap
    always_comb begin
        x_even = x_bit ? 2'b01 : 2'b10;
        x_word = (odd && rx_ready) ? ~x_even : x_even;
        y_even = y_bit ? 2'b11 : 2'b00;
        y_word = odd ? ~y_even : y_even;
        sa     = s_now ? x_word : y_word;
        sb     = s_now ? y_word : x_word;
    end

endmodule

// File: rtl/qpair_lane_map.sv
// Module: one line's four-level mapper followed by the sign flip.
// Assumes: pair is already scrambled; kind selects mapped, full-scale or zero.
module qpair_lane_map
    import qpair_pkg::*;
(
    input  logic       [1:0] pair,
    input  lane_kind_e       kind,
    input  logic             flip,
    output lvl_t             level
);

    lvl_t base;

    // Base level from the pair, then optional negation
    always_comb begin
        unique case (kind)
            LK_BITS: begin
                unique case (pair)
                    2'b01:   base = 3'sd1;
                    2'b00:   base = 3'sd0;
                    2'b10:   base = -3'sd1;
                    default: base = -3'sd2;
                endcase
            end
            LK_FULL: base = -3'sd2;
            default: base = 3'sd0;
        endcase
        level = flip ? (3'sd0 - base) : base;
    end

endmodule

// File: rtl/qpair_sym_enc.sv
// Module: quinary dual-pair symbol encoder top.
// Frames idle / start delimiter / data / end delimiter, scrambles the nibble
// and registers one level per line for each sym_en pulse.
// Assumes: sym_en is a one-cycle pulse per symbol; slave_sel is a static strap.
module qpair_sym_enc
    import qpair_pkg::*;
#(
    parameter logic [PRBS_LEN-1:0] SEED = 33'h1_5A5A_C3C3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_sel,
    input  logic             rx_ready,
    input  logic             tx_en,
    input  logic             sym_en,
    input  logic [3:0]       nib_i,
    output logic [LVL_W-1:0] a_o,
    output logic [LVL_W-1:0] b_o,
    output logic             sym_v_o
);

    frame_st_e  st, st_nx;
    sym_kind_e  kind;
    logic       odd;
    logic       s_now, a_bit, b_bit, x_bit, y_bit;
    logic [1:0] sa, sb;
    logic [3:0] nib_eff;
    logic [1:0] pair_raw [NLANE];
    logic [1:0] pair_scr [NLANE];
    logic       flip     [NLANE];
    lane_kind_e lk       [NLANE];
    lvl_t       lvl      [NLANE];

    qpair_prbs33 #(.SEED(SEED)) u_prbs (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (sym_en),
        .slave_sel (slave_sel),
        .s_now     (s_now),
        .a_bit     (a_bit),
        .b_bit     (b_bit),
        .x_bit     (x_bit),
        .y_bit     (y_bit)
    );

    qpair_scr_word u_word (
        .s_now    (s_now),
        .x_bit    (x_bit),
        .y_bit    (y_bit),
        .odd      (odd),
        .rx_ready (rx_ready),
        .sa       (sa),
        .sb       (sb)
    );

    // Symbol kind for this period and framer next state
    always_comb begin
        kind  = SK_IDLE;
        st_nx = st;
        unique case (st)
            FS_IDLE: if (tx_en) begin kind = SK_DEL1; st_nx = FS_SSD2; end
            FS_SSD2: begin kind = SK_DEL2; st_nx = FS_DATA; end
            FS_DATA: begin
                if (tx_en) kind = SK_DATA;
                else begin kind = SK_DEL1; st_nx = FS_ESD2; end
            end
            default: begin kind = SK_DEL2; st_nx = FS_IDLE; end
        endcase
    end

    // Nibble split into line pairs; idle and delimiters see zero data
    always_comb begin
        nib_eff     = (kind == SK_DATA) ? nib_i : 4'b0000;
        pair_raw[0] = {~nib_eff[2], nib_eff[3]};
        pair_raw[1] = {~nib_eff[0], nib_eff[1]};
        pair_scr[0] = pair_raw[0] ^ sa;
        pair_scr[1] = pair_raw[1] ^ sb;
        flip[0]     = a_bit;
        flip[1]     = b_bit;
    end

    // Per-lane base kind: delimiters force full scale, B is zero on the second
    generate
        for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
            always_comb begin
                if (kind == SK_DEL1)                    lk[ln] = LK_FULL;
                else if (kind == SK_DEL2 && ln == 0)    lk[ln] = LK_FULL;
                else if (kind == SK_DEL2)               lk[ln] = LK_ZERO;
                else                                    lk[ln] = LK_BITS;
            end

            qpair_lane_map u_map (
                .pair  (pair_scr[ln]),
                .kind  (lk[ln]),
                .flip  (flip[ln]),
                .level (lvl[ln])
            );
        end
    endgenerate

    // Framer state and symbol parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= FS_IDLE;
            odd <= 1'b0;
        end else if (sym_en) begin
            st  <= st_nx;
            odd <= ~odd;
        end
    end

    // Output registers and valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o     <= '0;
            b_o     <= '0;
            sym_v_o <= 1'b0;
        end else begin
            sym_v_o <= sym_en;
            if (sym_en) begin
                a_o <= lvl[0];
                b_o <= lvl[1];
            end
        end
    end

    a_r9_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
        sym_en |=> sym_v_o);

    a_r9_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_en |=> !sym_v_o);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_en |=> ($stable(a_o) && $stable(b_o)));

    a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
        (a_o != 3'b011) && (a_o != 3'b100) && (b_o != 3'b011) && (b_o != 3'b100));

    a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FS_IDLE && sym_en && tx_en) |=> st == FS_SSD2);

    a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FS_DATA && sym_en && !tx_en) |=> st == FS_ESD2);

    a_r8_second: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_en && (st == FS_SSD2 || st == FS_ESD2))
            |=> (b_o == 3'b000) && (a_o == 3'b010 || a_o == 3'b110));

endmodule

// File: tb/qpair_sym_enc_tb.sv
module qpair_sym_enc_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [32:0] SEED_V = 33'h1_5A5A_C3C3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_sel = 1'b0;
    logic       rx_ready = 1'b0;
    logic       tx_en = 1'b0;
    logic       sym_en = 1'b0;
    logic [3:0] nib_i = 4'h0;
    logic [2:0] a_o, b_o;
    logic       sym_v_o;

    int checks = 0;
    int errors = 0;

    // reference state: hist[k] = s[n-k]
    logic hist [1:33];
    logic m_odd;
    int   m_st;   // 0 idle, 1 second start delim, 2 data, 3 second end delim

    qpair_sym_enc #(.SEED(SEED_V)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slave_sel (slave_sel),
        .rx_ready  (rx_ready),
        .tx_en     (tx_en),
        .sym_en    (sym_en),
        .nib_i     (nib_i),
        .a_o       (a_o),
        .b_o       (b_o),
        .sym_v_o   (sym_v_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int map4(input logic [1:0] p);
        case (p)
            2'b01:   return 1;
            2'b00:   return 0;
            2'b10:   return -1;
            default: return -2;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 1; k <= 33; k++) hist[k] = SEED_V[k-1];
        m_odd = 1'b0;
        m_st  = 0;
    endtask

    // expected levels for one symbol; advances the reference
    task automatic model_sym(input logic [3:0] nib, input logic tx, input logic rdy,
                             output int ea, output int eb, output int kd);
        logic s, an, bn, xn, yn;
        logic [1:0] xw, yw, wa, wb, pa, pb;
        logic [3:0] d;
        s  = hist[33] ^ (slave_sel ? hist[20] : hist[13]);
        an = hist[1] ^ hist[5];
        bn = hist[2] ^ hist[12];
        xn = hist[3] ^ hist[8];
        yn = hist[4] ^ hist[6];
        xw = xn ? 2'b01 : 2'b10;
        if (rdy && m_odd) xw = ~xw;
        yw = yn ? 2'b11 : 2'b00;
        if (m_odd) yw = ~yw;
        wa = s ? xw : yw;
        wb = s ? yw : xw;
        // kd: 0 idle, 1 data, 2 first delimiter, 3 second delimiter
        case (m_st)
            0: begin kd = tx ? 2 : 0; m_st = tx ? 1 : 0; end
            1: begin kd = 3; m_st = 2; end
            2: begin kd = tx ? 1 : 2; m_st = tx ? 2 : 3; end
            default: begin kd = 3; m_st = 0; end
        endcase
        d  = (kd == 1) ? nib : 4'h0;
        pa = {~d[2], d[3]} ^ wa;
        pb = {~d[0], d[1]} ^ wb;
        if (kd >= 2) begin
            ea = -2;
            eb = (kd == 2) ? -2 : 0;
        end else begin
            ea = map4(pa);
            eb = map4(pb);
        end
        if (an) ea = -ea;
        if (bn) eb = -eb;
        for (int k = 33; k >= 2; k--) hist[k] = hist[k-1];
        hist[1] = s;
        m_odd = ~m_odd;
    endtask

    // one symbol, then optional gap cycles
    task automatic do_sym(input logic [3:0] nib, input logic tx, input logic rdy, input int gap);
        int ea, eb, kd;
        logic [2:0] ha, hb;
        @(negedge clk);
        nib_i = nib; tx_en = tx; rx_ready = rdy; sym_en = 1'b1;
        model_sym(nib, tx, rdy, ea, eb, kd);
        @(negedge clk);
        sym_en = 1'b0;
        nib_i = 4'($urandom_range(15, 0));
        check(sym_v_o == 1'b1, "R9 valid after sym_en", int'(sym_v_o), 1);
        case (kd)
            0: begin
                check($signed(a_o) == ea, "R11 idle line A", $signed(a_o), ea);
                check($signed(b_o) == eb, "R11 idle line B", $signed(b_o), eb);
            end
            1: begin
                check($signed(a_o) == ea, "R3 R4 R5 R6 data line A", $signed(a_o), ea);
                check($signed(b_o) == eb, "R3 R4 R5 R6 data line B", $signed(b_o), eb);
            end
            default: begin
                check($signed(a_o) == ea, "R7 R8 delimiter line A", $signed(a_o), ea);
                check($signed(b_o) == eb, "R7 R8 delimiter line B", $signed(b_o), eb);
            end
        endcase
        check(a_o != 3'b011 && a_o != 3'b100 && b_o != 3'b011 && b_o != 3'b100,
              "R10 level range", int'(a_o), 0);
        ha = a_o; hb = b_o;
        for (int g = 0; g < gap; g++) begin
            tx_en = ~tx_en;
            @(negedge clk);
            check(sym_v_o == 1'b0, "R9 no valid in gap", int'(sym_v_o), 0);
            check(a_o == ha && b_o == hb, "R2 R9 hold in gap", int'(a_o), int'(ha));
        end
    endtask

    task automatic do_reset(input logic slv);
        @(negedge clk);
        rst_n = 1'b0; slave_sel = slv; sym_en = 1'b0; tx_en = 1'b0;
        repeat (3) @(negedge clk);
        check(a_o == 3'b000, "R1 reset line A", int'(a_o), 0);
        check(b_o == 3'b000, "R1 reset line B", int'(b_o), 0);
        check(sym_v_o == 1'b0, "R1 reset valid", int'(sym_v_o), 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++)
            do_sym(4'($urandom_range(15, 0)), ($urandom_range(3, 0) != 0),
                   ($urandom_range(3, 0) != 0), ($urandom_range(3, 0) == 0) ? 2 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // master strap
        do_reset(1'b0);
        // idle with receiver not ready, then ready (R4 parity on X)
        for (int i = 0; i < 24; i++) do_sym(4'h0, 1'b0, 1'b0, i % 3);
        for (int i = 0; i < 24; i++) do_sym(4'hF, 1'b0, 1'b1, 0);
        // a frame of random data
        for (int i = 0; i < 40; i++) do_sym(4'($urandom_range(15, 0)), 1'b1, 1'b1, 0);
        do_sym(4'h0, 1'b0, 1'b1, 0);
        do_sym(4'h0, 1'b1, 1'b1, 0);   // tx_en ignored on second end delimiter
        do_sym(4'h0, 1'b0, 1'b1, 0);
        // one-symbol request: second start delimiter ignores tx_en low
        do_sym(4'h5, 1'b1, 1'b0, 0);
        do_sym(4'hA, 1'b0, 1'b0, 0);
        do_sym(4'h0, 1'b1, 1'b0, 0);
        do_sym(4'hF, 1'b1, 1'b0, 0);
        do_sym(4'h0, 1'b1, 1'b1, 1);
        do_sym(4'hF, 1'b0, 1'b1, 0);
        do_sym(4'h3, 1'b0, 1'b1, 0);
        random_run(400);
        // slave strap
        do_reset(1'b1);
        for (int i = 0; i < 30; i++) do_sym(4'h0, 1'b0, 1'b1, 0);
        random_run(300);
        // reset mid-frame returns to idle with seed
        do_sym(4'h9, 1'b1, 1'b1, 0);
        do_reset(1'b0);
        random_run(100);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule